// File: doc/BRIEF.md
# Next program counter selector

This block owns the program counter of a 32-bit single-cycle core. Each cycle it forms the sequential address (PC plus 4), a relative branch target, an absolute jump target inside the current 256 MB region, and takes a register value for register-indirect jumps. A 2-bit source select picks which of these becomes the next PC. On a clock edge where stepping is enabled and no halt is requested, the register loads that value.

Branch direction is resolved inside the block from an external zero flag (the result of comparing the two branch operands) and a sense bit. With the sense bit low the branch is taken on equality; with it high the flag is inverted, so the branch is taken on inequality. The sequential address is also the output used as the return address by a jump-and-link, so decode can write it into the link register while the PC moves to the jump target.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `pc` becomes `RESET_ADDR`, and reset takes priority over `halt` and `step_en`.
- R2: `seq_addr` always equals `pc + 4` (modulo 2^32); with `pc_sel` = 2'b00 `next_pc` equals `seq_addr`.
- R3: With `pc_sel` = 2'b01 and the branch taken, `next_pc` is `seq_addr` plus the sign-extended `br_imm` multiplied by 4; when not taken, `next_pc` equals `seq_addr`.
- R4: With `br_on_ne` = 0 (equal sense), the branch is taken exactly when `cmp_zero` = 1.
- R5: With `br_on_ne` = 1 (not-equal sense), the branch is taken exactly when `cmp_zero` = 0.
- R6: With `pc_sel` = 2'b10, `next_pc` equals `reg_target` unchanged, all 32 bits.
- R7: With `pc_sel` = 2'b11, `next_pc` is bits 31..28 of `seq_addr`, then the 26-bit `jmp_index`, then two zero bits; `seq_addr` still shows `pc + 4` as the link value.
- R8: At a rising edge with `rst_n` = 1, `step_en` = 1 and `halt` = 0, `pc` loads the `next_pc` value present before that edge.
- R9: At a rising edge with `rst_n` = 1 and `halt` = 1, `pc` keeps its value whatever `step_en` and `pc_sel` are.
- R10: At a rising edge with `rst_n` = 1 and `step_en` = 0, `pc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Allows the PC to advance on this edge |
| halt | input | 1 | Freezes the PC while high |
| pc_sel | input | 2 | Next-PC source: 00 sequential, 01 branch, 10 register, 11 jump |
| cmp_zero | input | 1 | Zero flag of the branch operand compare (1 = equal) |
| br_on_ne | input | 1 | Branch sense: 0 taken on equal, 1 taken on not equal |
| reg_target | input | XLEN | Register operand for register-indirect jumps |
| br_imm | input | IMM_W | Branch word offset, signed |
| jmp_index | input | IDX_W | Word index of an absolute jump |
| pc | output | XLEN | Current program counter |
| seq_addr | output | XLEN | PC + 4, also the link value |
| next_pc | output | XLEN | Selected next program counter |

## Verification
Halt and a control transfer can meet in one cycle: the bench drives a taken branch, a register jump or an absolute jump while `halt` is high, and judges that `next_pc` still shows the selected target while `pc` stays put at the following edge. Reset can likewise coincide with an enabled step and halt; the reference model gives reset priority and the bench checks that `pc` lands on the reset address. Branch offsets at both ends of their range and jumps from the top region of the address space show sign extension and region retention.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

    typedef enum logic [1:0] {
        PCS_SEQ    = 2'b00,
        PCS_BRANCH = 2'b01,
        PCS_REG    = 2'b10,
        PCS_JUMP   = 2'b11
    } pc_src_e;

    localparam int unsigned INSN_BYTES_LOG2 = 2;

endpackage

// File: rtl/pc_branch_resolve.sv
module pc_branch_resolve (
    input  logic cmp_zero,
    input  logic sense_ne,
    output logic taken
);
    // Equal sense follows the zero flag; not-equal sense inverts it.
    always_comb begin
        taken = cmp_zero ^ sense_ne;
    end
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
    import pc_next_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [IMM_W-1:0] br_imm,
    input  logic [IDX_W-1:0] jmp_index,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  br_target,
    output logic [XLEN-1:0]  jmp_target
);
    localparam int unsigned SH       = INSN_BYTES_LOG2;
    localparam int unsigned EXT_W    = XLEN - IMM_W - SH;
    localparam int unsigned REGION_W = XLEN - IDX_W - SH;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << SH);

    logic [XLEN-1:0] offset_bytes;

    always_comb begin
        seq_addr     = pc_cur + STEP;
        offset_bytes = {{EXT_W{br_imm[IMM_W-1]}}, br_imm, {SH{1'b0}}};
        br_target    = seq_addr + offset_bytes;
        jmp_target   = {seq_addr[XLEN-1 -: REGION_W], jmp_index, {SH{1'b0}}};
    end
endmodule

// File: rtl/pc_src_mux.sv
module pc_src_mux
    import pc_next_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [1:0]      sel,
    input  logic            br_taken,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] reg_target,
    input  logic [XLEN-1:0] jmp_target,
    output logic [XLEN-1:0] next_pc
);
    always_comb begin
        unique case (pc_src_e'(sel))
            PCS_SEQ:    next_pc = seq_addr;
            PCS_BRANCH: next_pc = br_taken ? br_target : seq_addr;
            PCS_REG:    next_pc = reg_target;
            PCS_JUMP:   next_pc = jmp_target;
            default:    next_pc = seq_addr;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pc_next_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IMM_W      = 16,
    parameter int unsigned IDX_W      = 26,
    parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             halt,
    input  logic [1:0]       pc_sel,
    input  logic             cmp_zero,
    input  logic             br_on_ne,
    input  logic [XLEN-1:0]  reg_target,
    input  logic [IMM_W-1:0] br_imm,
    input  logic [IDX_W-1:0] jmp_index,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  next_pc
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t state_d, state_q;

    logic            br_taken;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            advance;

    pc_branch_resolve u_resolve (
        .cmp_zero (cmp_zero),
        .sense_ne (br_on_ne),
        .taken    (br_taken)
    );

    pc_target_gen #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .IDX_W (IDX_W)
    ) u_targets (
        .pc_cur     (state_q.pc),
        .br_imm     (br_imm),
        .jmp_index  (jmp_index),
        .seq_addr   (seq_addr),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    pc_src_mux #(
        .XLEN (XLEN)
    ) u_mux (
        .sel        (pc_sel),
        .br_taken   (br_taken),
        .seq_addr   (seq_addr),
        .br_target  (br_target),
        .reg_target (reg_target),
        .jmp_target (jmp_target),
        .next_pc    (next_pc)
    );

    always_comb begin
        advance  = step_en && !halt;
        state_d  = state_q;
        if (advance) begin
            state_d.pc = next_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc <= RESET_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc = state_q.pc;

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_ADDR);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !halt && pc_sel == 2'b00) |=> pc == $past(pc) + XLEN'(4));

    // R3
    br_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !halt && pc_sel == 2'b01 && !br_taken) |=> pc == $past(seq_addr));

    // R6
    reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !halt && pc_sel == 2'b10) |=> pc == $past(reg_target));

    // R8
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !halt) |=> pc == $past(next_pc));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(pc));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc));

endmodule

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
    localparam logic [31:0] RST_PC = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en;
    logic        halt;
    logic [1:0]  pc_sel;
    logic        cmp_zero;
    logic        br_on_ne;
    logic [31:0] reg_target;
    logic [15:0] br_imm;
    logic [25:0] jmp_index;
    logic [31:0] pc;
    logic [31:0] seq_addr;
    logic [31:0] next_pc;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] model_pc;

    always #2.5 clk = ~clk;

    pc_next_unit #(.RESET_ADDR(RST_PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .halt(halt),
        .pc_sel(pc_sel), .cmp_zero(cmp_zero), .br_on_ne(br_on_ne),
        .reg_target(reg_target), .br_imm(br_imm), .jmp_index(jmp_index),
        .pc(pc), .seq_addr(seq_addr), .next_pc(next_pc)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_next(logic [31:0] cur, logic [1:0] s, logic z,
                                             logic ne, logic [31:0] r, logic [15:0] imm,
                                             logic [25:0] idx);
        logic [31:0] nxt;
        int          off;
        bit          tk;
        nxt = cur + 32'd4;
        off = int'($signed(imm)) * 4;
        tk  = ne ? (z == 1'b0) : (z == 1'b1);
        case (s)
            2'd0: return nxt;
            2'd1: return tk ? nxt + 32'(off) : nxt;
            2'd2: return r;
            default: return (nxt & 32'hF000_0000) | (32'(idx) * 32'd4);
        endcase
    endfunction

    // Drives one cycle: inputs set away from the edge, combinational outputs
    // checked, then the register compared against the model after the edge.
    task automatic cyc(string req, logic rn, logic st, logic hl, logic [1:0] s, logic z,
                       logic ne, logic [31:0] r, logic [15:0] imm, logic [25:0] idx);
        logic [31:0] exp_n;
        rst_n = rn; step_en = st; halt = hl; pc_sel = s; cmp_zero = z;
        br_on_ne = ne; reg_target = r; br_imm = imm; jmp_index = idx;
        #1;
        exp_n = ref_next(model_pc, s, z, ne, r, imm, idx);
        if (rn) begin
            check({req, "/R2 link"}, seq_addr, model_pc + 32'd4);
            check({req, " next"}, next_pc, exp_n);
        end
        @(posedge clk);
        if (!rn) model_pc = RST_PC;
        else if (st && !hl) model_pc = exp_n;
        #1;
        check({req, " pc"}, pc, model_pc);
    endtask

    initial begin
        model_pc = 32'h0;
        @(posedge clk); #1;
        // R1 reset, also with step and halt active
        cyc("R1", 0, 1, 1, 2'd3, 0, 0, 32'h0, 16'h0, 26'h0);
        cyc("R1", 0, 1, 0, 2'd2, 0, 0, 32'hDEAD_BEE0, 16'h0, 26'h0);
        // R2 sequential
        cyc("R2", 1, 1, 0, 2'd0, 0, 0, 32'h0, 16'h0, 26'h0);
        cyc("R2", 1, 1, 0, 2'd0, 1, 1, 32'h1234, 16'h7FFF, 26'h3);
        // R4 equal-sense branch, taken and not
        cyc("R4", 1, 1, 0, 2'd1, 1, 0, 32'h0, 16'h0010, 26'h0);
        cyc("R4", 1, 1, 0, 2'd1, 0, 0, 32'h0, 16'h0010, 26'h0);
        // R5 not-equal sense
        cyc("R5", 1, 1, 0, 2'd1, 0, 1, 32'h0, 16'h0020, 26'h0);
        cyc("R5", 1, 1, 0, 2'd1, 1, 1, 32'h0, 16'h0020, 26'h0);
        // R3 offset extremes: -1 word (self loop), most negative, most positive
        cyc("R3", 1, 1, 0, 2'd1, 1, 0, 32'h0, 16'hFFFF, 26'h0);
        cyc("R3", 1, 1, 0, 2'd1, 1, 0, 32'h0, 16'h8000, 26'h0);
        cyc("R3", 1, 1, 0, 2'd1, 1, 0, 32'h0, 16'h7FFF, 26'h0);
        // R6 register jump, unaligned value passes untouched
        cyc("R6", 1, 1, 0, 2'd2, 0, 0, 32'hF000_0FFE, 16'h0, 26'h0);
        // R7 jump keeps upper region of PC+4
        cyc("R7", 1, 1, 0, 2'd3, 0, 0, 32'h0, 16'h0, 26'h3FF_FFFF);
        cyc("R7", 1, 1, 0, 2'd3, 0, 0, 32'h0, 16'h0, 26'h000_0001);
        // R9 halt together with each transfer kind
        cyc("R9", 1, 1, 1, 2'd1, 1, 0, 32'h0, 16'h0100, 26'h0);
        cyc("R9", 1, 1, 1, 2'd2, 0, 0, 32'h8000_0000, 16'h0, 26'h0);
        cyc("R9", 1, 0, 1, 2'd3, 0, 0, 32'h0, 16'h0, 26'h12345);
        // R10 stall
        cyc("R10", 1, 0, 0, 2'd2, 0, 0, 32'h0000_0ABC, 16'h0, 26'h0);
        cyc("R10", 1, 0, 0, 2'd0, 0, 0, 32'h0, 16'h0, 26'h0);
        // R2 wrap at top of address space
        cyc("R6", 1, 1, 0, 2'd2, 0, 0, 32'hFFFF_FFFC, 16'h0, 26'h0);
        cyc("R2", 1, 1, 0, 2'd0, 0, 0, 32'h0, 16'h0, 26'h0);
        // R8 mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cyc("R8", (rv[3:0] != 0), (rv[6:4] != 0), (rv[9:7] == 0), rv[11:10],
                rv[12], rv[13], $urandom, 16'($urandom), 26'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule